// File: doc/BRIEF.md
# Staggered Region Wake-Up Sequencer

This block sits between a run-time power policy and a set of power-gated regions. Each region has a request bit: high means the policy wants the region on, low means it wants it asleep. The block turns regions off as soon as their request drops. It powers requested regions up only in small groups, so that the inrush current from a large block charging its floating nodes never hits the supply all at once.

After each group is switched on, the sequencer waits a programmable number of clock cycles so that the rail can recover. Only then does it raise a per-region ready flag, and the policy waits for that flag before it uses the region. Pending requests are taken lowest index first. A request that is withdrawn while it waits in the queue is simply dropped.

Top module: `region_wake_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `pwr_en` and `ready` is low after that edge.
- R2: At any single clock edge, at most `GROUP_MAX` bits of `pwr_en` change from 0 to 1.
- R3: Each group is made of the lowest-indexed regions (bit 0 first) whose request is high and whose `pwr_en` is low, up to `GROUP_MAX` of them.
- R4: A region's `ready` rises exactly `S`+2 clock edges after its `pwr_en` rose. `S` is the value on `settle_cycles` at the edge where `pwr_en` rose.
- R5: The `pwr_en` rise of a new group comes no earlier than 2 edges after the previous group's `ready` rise.
- R6: `ready` is high only while `pwr_en` is high, and it stays high for as long as the region's request stays high.
- R7: When a region's request is low at an edge, its `pwr_en` and its `ready` are both low after that edge.
- R8: A region whose request is withdrawn before its group is switched on is never powered for that request.
- R9: A change to `settle_cycles` during a settle wait has no effect on the group that is already waiting.
- R10: A request for a region that is already powered leaves its `pwr_en` and `ready` unchanged, and every request that stays high is eventually served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awake_req | input | NUM_REGIONS | Per-region request: 1 = want powered, 0 = sleep |
| settle_cycles | input | SETTLE_W | Settle wait length in cycles, taken when a group is enabled |
| pwr_en | output | NUM_REGIONS | Per-region power switch enable, registered |
| ready | output | NUM_REGIONS | Per-region wake completion, registered |

## Verification
The bench builds the block with six regions and a group size of two, instead of the default of one. This lets a single step carry a real group, so a step that picks two regions out of a wider set of pending requests tests both the group limit and the ascending-index choice. The bench uses settle lengths of zero, three and five. Zero reaches the shortest legal delay from enable to ready. The non-zero lengths leave room to withdraw queued requests and to change the settle input while a group is still waiting.

// File: rtl/region_wake_pkg.sv
package region_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ENABLE = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wake_group_pick.sv
module wake_group_pick #(
  parameter int NUM_REGIONS = 8,
  parameter int GROUP_MAX   = 1
) (
  input  logic [NUM_REGIONS-1:0] pending,
  output logic [NUM_REGIONS-1:0] pick
);
  // lowest indices first, capped at GROUP_MAX
  always_comb begin
    int taken;
    taken = 0;
    pick  = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (pending[i] && (taken < GROUP_MAX)) begin
        pick[i] = 1'b1;
        taken   = taken + 1;
      end
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                run,
  output logic                expired
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/region_wake_seq.sv
module region_wake_seq #(
  parameter int NUM_REGIONS = 8,
  parameter int GROUP_MAX   = 1,
  parameter int SETTLE_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_REGIONS-1:0] awake_req,
  input  logic [SETTLE_W-1:0]    settle_cycles,
  output logic [NUM_REGIONS-1:0] pwr_en,
  output logic [NUM_REGIONS-1:0] ready
);
  import region_wake_pkg::*;

  seq_state_t state_q, state_d;
  logic [NUM_REGIONS-1:0] pwr_q, pwr_d;
  logic [NUM_REGIONS-1:0] rdy_q, rdy_d;
  logic [NUM_REGIONS-1:0] grp_q, grp_d;
  logic [NUM_REGIONS-1:0] pending, pick;
  logic tmr_load, tmr_expired;

  // requested but not yet powered; a withdrawn request leaves this set at once
  assign pending = awake_req & ~pwr_q;

  wake_group_pick #(.NUM_REGIONS(NUM_REGIONS), .GROUP_MAX(GROUP_MAX)) pick_i (
    .pending (pending),
    .pick    (pick)
  );

  assign tmr_load = (state_q == ST_ENABLE);

  settle_timer #(.SETTLE_W(SETTLE_W)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (settle_cycles),
    .run      (state_q == ST_SETTLE),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    pwr_d   = pwr_q;
    rdy_d   = rdy_q;
    grp_d   = grp_q;
    unique case (state_q)
      ST_IDLE:   if (|pending) state_d = ST_ENABLE;
      ST_ENABLE: begin
        pwr_d   = pwr_q | pick;
        grp_d   = pick;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_expired) state_d = ST_DONE;
      ST_DONE: begin
        rdy_d   = rdy_q | (grp_q & pwr_q & awake_req);
        grp_d   = '0;
        state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
    // sleep wins over everything in the same cycle
    pwr_d = pwr_d & awake_req;
    rdy_d = rdy_d & awake_req;
    grp_d = grp_d & awake_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pwr_q   <= '0;
      rdy_q   <= '0;
      grp_q   <= '0;
    end else begin
      state_q <= state_d;
      pwr_q   <= pwr_d;
      rdy_q   <= rdy_d;
      grp_q   <= grp_d;
    end
  end

  assign pwr_en = pwr_q;
  assign ready  = rdy_q;
endmodule

// File: rtl/region_wake_seq_chk.sv
module region_wake_seq_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int GROUP_MAX   = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_REGIONS-1:0] awake_req,
  input logic [NUM_REGIONS-1:0] pwr_en,
  input logic [NUM_REGIONS-1:0] ready
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pwr_en == '0) && (ready == '0));

  assert_group_cap_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(pwr_en & ~$past(pwr_en)) <= GROUP_MAX));

  assert_ready_after_power_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ready & ~$past(ready) & ~$past(pwr_en)) == '0));

  assert_ready_needs_power_R6: assert property (@(posedge clk) disable iff (rst)
    (ready & ~pwr_en) == '0);

  assert_sleep_drops_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pwr_en | ready) & ~$past(awake_req)) == '0));
endmodule

bind region_wake_seq region_wake_seq_chk #(
  .NUM_REGIONS(NUM_REGIONS),
  .GROUP_MAX(GROUP_MAX)
) chk_i (
  .clk(clk), .rst(rst), .awake_req(awake_req), .pwr_en(pwr_en), .ready(ready)
);

// File: tb/region_wake_seq_tb.sv
module region_wake_seq_tb_top;
  localparam int N  = 6;
  localparam int G  = 2;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  awake_req = '0;
  logic [SW-1:0] settle_cycles = '0;
  logic [N-1:0]  pwr_en, ready;

  always #10 clk = ~clk;

  region_wake_seq #(.NUM_REGIONS(N), .GROUP_MAX(G), .SETTLE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .awake_req(awake_req), .settle_cycles(settle_cycles),
    .pwr_en(pwr_en), .ready(ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference: phase 0 wait, 1 pick, 2 settle, 3 complete
  int m_phase = 0;
  int m_cnt = 0;
  bit m_pwr[N];
  bit m_rdy[N];
  bit m_grp[N];

  function automatic logic [N-1:0] pack(input bit a[N]);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = a[i];
    return v;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_phase = 0; m_cnt = 0;
      for (int i = 0; i < N; i++) begin m_pwr[i] = 0; m_rdy[i] = 0; m_grp[i] = 0; end
    end else begin
      bit np[N], nr[N], ng[N];
      int taken;
      int nphase;
      bit any;
      any = 0;
      for (int i = 0; i < N; i++) begin
        np[i] = m_pwr[i]; nr[i] = m_rdy[i]; ng[i] = m_grp[i];
        if (awake_req[i] && !m_pwr[i]) any = 1;
      end
      nphase = m_phase;
      if (m_phase == 0) begin
        if (any) nphase = 1;
      end else if (m_phase == 1) begin
        taken = 0;
        for (int i = 0; i < N; i++) begin
          ng[i] = 0;
          if (awake_req[i] && !m_pwr[i] && taken < G) begin
            np[i] = 1; ng[i] = 1; taken++;
          end
        end
        m_cnt = int'(settle_cycles);
        nphase = 2;
      end else if (m_phase == 2) begin
        if (m_cnt == 0) nphase = 3; else m_cnt = m_cnt - 1;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (m_grp[i] && m_pwr[i] && awake_req[i]) nr[i] = 1;
          ng[i] = 0;
        end
        nphase = 0;
      end
      for (int i = 0; i < N; i++) begin
        if (!awake_req[i]) begin np[i] = 0; nr[i] = 0; ng[i] = 0; end
        m_pwr[i] = np[i]; m_rdy[i] = nr[i]; m_grp[i] = ng[i];
      end
      m_phase = nphase;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // direct timing checks, sampled at the falling edge
  logic [N-1:0] prev_pwr = '0, prev_rdy = '0;
  int rise_cyc[N];
  int rise_set[N];
  int last_rdy_rise = -100;
  bit ever_pwr5 = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check(pwr_en == pack(m_pwr), "R3 pwr_en vs model", pwr_en, pack(m_pwr));
      check(ready == pack(m_rdy), "R9 ready vs model", ready, pack(m_rdy));
      check($countones(pwr_en & ~prev_pwr) <= G, "R2 rises per edge",
            $countones(pwr_en & ~prev_pwr), G);
      check((ready & ~pwr_en) == '0, "R6 ready without power", ready, pwr_en);
      if ((pwr_en & ~prev_pwr) != '0)
        check(cyc >= last_rdy_rise + 2, "R5 step spacing", cyc, last_rdy_rise + 2);
      for (int i = 0; i < N; i++) begin
        if (pwr_en[i] && !prev_pwr[i]) begin
          rise_cyc[i] = cyc;
          rise_set[i] = int'(settle_cycles);
        end
        if (ready[i] && !prev_rdy[i]) begin
          check(cyc - rise_cyc[i] == rise_set[i] + 2, "R4 ready delay",
                cyc - rise_cyc[i], rise_set[i] + 2);
          last_rdy_rise = cyc;
        end
      end
      if (pwr_en[5]) ever_pwr5 = 1;
    end
    prev_pwr = pwr_en;
    prev_rdy = ready;
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(20000 * 20);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    check(pwr_en == '0, "R1 reset pwr_en", pwr_en, 0);
    check(ready == '0, "R1 reset ready", ready, 0);
    rst = 1'b0;

    // all six at once, settle 3: groups {0,1},{2,3},{4,5}
    settle_cycles = 8'd3;
    awake_req = 6'b111111;
    step(3);
    check(pwr_en == 6'b000011, "R3 first group lowest indices", pwr_en, 6'b000011);
    step(40);
    check(ready == 6'b111111, "R10 all served", ready, 6'b111111);

    // sleep 1 and 4
    awake_req = 6'b101101;
    step(1);
    check((pwr_en & 6'b010010) == '0, "R7 sleep drops power", pwr_en, 6'b101101);
    check((ready & 6'b010010) == '0, "R7 sleep drops ready", ready, 6'b101101);
    check(ready == 6'b101101, "R10 others untouched", ready, 6'b101101);

    // re-request 1 and 4 with zero settle: one group
    settle_cycles = 8'd0;
    awake_req = 6'b111111;
    step(20);
    check(ready == 6'b111111, "R4 zero settle served", ready, 6'b111111);

    // cancel a queued request and change settle mid-wait
    awake_req = '0;
    step(2);
    ever_pwr5 = 0;
    settle_cycles = 8'd5;
    awake_req = 6'b101101;
    step(4);
    settle_cycles = 8'd1;
    awake_req = 6'b001101;
    step(40);
    check(ever_pwr5 == 0, "R8 cancelled region stayed off", ever_pwr5, 0);
    check(ready == 6'b001101, "R9 remaining served", ready, 6'b001101);

    // reset mid-operation
    awake_req = 6'b110000;
    step(3);
    rst = 1'b1;
    step(2);
    check(pwr_en == '0 && ready == '0, "R1 reset mid-run", {pwr_en, ready}, 0);
    rst = 1'b0;
    awake_req = '0;
    step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule